// File: doc/BRIEF.md
# Mailbox Request Sequencer

This engine runs the requester side of a 256-bit shared mailbox. The mailbox is eight 32-bit words, and word 7 carries a control header whose top bit marks the far side as owner. The engine serves two request kinds. A setup request carries four queue base addresses, an interrupt vector index and a reset flag. A teardown request carries only the reset flag. The engine first waits until it owns the mailbox. It then checks the arguments and writes the message, with the header always last. Next it polls until ownership comes back, and finally checks the reply. It finishes with a one-cycle done pulse and a two-bit result.

The mailbox is reached through a simple word-addressed master port. A request channel (`bus_valid`/`bus_ready`) carries reads and writes. A read reply comes back on `rd_valid`/`rd_data` at any later cycle, with no back-pressure on replies. Back-pressure rules:
- While `bus_valid` is high and `bus_ready` is low, the engine holds the address, the direction and the write data steady.
- The engine never has more than one read outstanding.
- The engine issues no new request until the reply to the current read has arrived.

The control pins (`start`, `busy`, `done`, `result`) are plain level and pulse signals.

Top module: `mbx_req_seq`

## Requirements
- R1: Before writing, the engine reads word 7 until bit 31 reads 0. Every read it issues targets word 7. In this first wait an all-ones word counts as owned by the far side, even when the reset flag is set.
- R2: The engine makes at most POLL_LIMIT reads in any one wait. Consecutive reads in a wait are more than POLL_GAP cycles apart. If the last of these reads still has bit 31 set, the request ends with result 2 (timeout).
- R3: A setup request with any address whose bits [11:0] are not zero, or with a vector index of 65536 or more, ends with result 1 (bad argument) and makes no write. A vector index of 65535 is accepted.
- R4: The frame number of each address is address bits [63:12]. Its low 48 bits go little-endian into message bytes 0-5, 6-11, 12-17 and 18-23 for the first, second, third and fourth address. Message byte k is bits [8(k mod 4)+7 : 8(k mod 4)] of word k/4.
- R5: Bytes 24-25 form a 16-bit field that holds frame-number bits [51:48] of the four addresses at field bits [3:0], [7:4], [11:8] and [15:12], in address order.
- R6: The vector index fills bytes 26-27. The header in word 7 is laid out as follows: kind at bits [2:0], version at [5:3], direction at bit 7, status at [15:8], reset flag at bit 24 and owner at bit 31. A request header carries kind 1 (setup) or 2 (teardown), version 0, direction 0, status 0 and the reset flag.
- R7: A setup request writes words 0 to 7 in ascending order. A teardown request writes only word 7.
- R8: After the header write, the engine polls word 7 (R1, R2) until it is released. The reply is accepted as result 0 (ok) only if all of the following hold: the kind matches the request, the version is 0 or less, the direction is 1 and the status is 0. Any other reply gives result 3 (protocol error).
- R9: With the reset flag set, an all-ones word read after the header write ends the wait and gives result 0. Without the flag, the same word keeps the engine polling.
- R10: `done` is high for exactly one cycle per accepted request and carries `result`. `busy` is high from the cycle after an accepted start until `done`, and is low afterwards. A `start` pulse while `busy` is high is ignored.
- R11: A request held without `bus_ready` stays unchanged, and no request is issued while a read reply is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, sampled only while idle |
| op_teardown | input | 1 | 0 = setup request, 1 = teardown request |
| reset_flag | input | 1 | Reset flag carried in the header; enables the all-ones reply rule |
| eq_addr | input | ADDR_W | First queue base address |
| cq_addr | input | ADDR_W | Second queue base address |
| rq_addr | input | ADDR_W | Third queue base address |
| sq_addr | input | ADDR_W | Fourth queue base address |
| vec_idx | input | VIDX_W | Interrupt vector index |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 bad argument, 2 timeout, 3 protocol error |
| bus_valid | output | 1 | Mailbox request valid |
| bus_ready | input | 1 | Mailbox request accepted |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 3 | Mailbox word index |
| bus_wdata | output | 32 | Write data |
| rd_valid | input | 1 | Read reply valid |
| rd_data | input | 32 | Read reply data |

## Verification
The bench builds the engine with POLL_LIMIT = 6 and POLL_GAP = 3. With these values, both waits can be driven into timeout within a few dozen cycles, and the exact number of reads per wait and the spacing between them can be checked. The bench also keeps the default 64-bit addresses and 12-bit page offset. This lets it set the top address nibbles, so the high-nibble field and the 16-bit vector boundary are exercised at full width.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int MSG_WORDS = 8;
  localparam int WORD_W    = 32;
  localparam int MSG_W     = MSG_WORDS * WORD_W;
  localparam logic [2:0] HDR_WORD = 3'd7;

  localparam logic [2:0] KIND_SETUP    = 3'd1;
  localparam logic [2:0] KIND_TEARDOWN = 3'd2;
  localparam logic [2:0] REQ_VERSION   = 3'd0;

  // header field positions, decoded by the far side
  localparam int F_KIND_LO = 0;
  localparam int F_VER_LO  = 3;
  localparam int F_DIR     = 7;
  localparam int F_STAT_LO = 8;
  localparam int F_RSTF    = 24;
  localparam int F_OWNER   = 31;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_BADARG  = 2'd1,
    RES_TIMEOUT = 2'd2,
    RES_PROTO   = 2'd3
  } mbx_result_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_RWAIT, S_GAP, S_WR, S_FIN
  } mbx_state_e;

  function automatic logic [WORD_W-1:0] make_header(input logic [2:0] kind,
                                                    input logic       rflag);
    logic [WORD_W-1:0] h;
    h = '0;
    h[F_KIND_LO +: 3] = kind;
    h[F_VER_LO  +: 3] = REQ_VERSION;
    h[F_DIR]          = 1'b0;
    h[F_RSTF]         = rflag;
    return h;
  endfunction
endpackage

// File: rtl/mbx_msg_packer.sv
module mbx_msg_packer
  import mbx_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int VIDX_W     = 32,
  parameter int NQ         = 4,
  parameter int LOW_W      = 48,
  parameter int VEC_W      = 16
) (
  input  logic [NQ-1:0][ADDR_W-1:0] addrs,
  input  logic [VIDX_W-1:0]         vec,
  input  logic [WORD_W-1:0]         hdr,
  output logic [MSG_W-1:0]          msg,
  output logic                      args_ok
);
  localparam int FRAME_W = ADDR_W - PAGE_SHIFT;
  localparam int NIB_W   = FRAME_W - LOW_W;

  logic [NQ*LOW_W-1:0] low_field;
  logic [NQ*NIB_W-1:0] nib_field;
  logic [NQ-1:0]       aligned;
  logic                vec_fits;

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    logic [FRAME_W-1:0] frame;
    assign frame                          = addrs[q][ADDR_W-1:PAGE_SHIFT];
    assign low_field[q*LOW_W +: LOW_W]    = frame[LOW_W-1:0];
    assign nib_field[q*NIB_W +: NIB_W]    = frame[FRAME_W-1:LOW_W];
    assign aligned[q]                     = (addrs[q][PAGE_SHIFT-1:0] == '0);
  end

  if (VIDX_W > VEC_W) begin : g_vec_wide
    assign vec_fits = (vec[VIDX_W-1:VEC_W] == '0);
  end else begin : g_vec_narrow
    assign vec_fits = 1'b1;
  end

  assign msg     = {hdr, vec[VEC_W-1:0], nib_field, low_field};
  assign args_ok = (&aligned) & vec_fits;
endmodule

// File: rtl/mbx_poll_timer.sv
module mbx_poll_timer #(
  parameter int LIMIT = 20000,
  parameter int GAP   = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic miss,
  output logic last,
  output logic gap_idle
);
  localparam int AW = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;
  localparam int GW = (GAP > 0) ? $clog2(GAP + 1) : 1;

  logic [AW-1:0] tries;
  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tries   <= '0;
      gap_cnt <= '0;
    end else if (clr) begin
      tries   <= '0;
      gap_cnt <= '0;
    end else if (miss) begin
      tries   <= tries + 1'b1;
      gap_cnt <= GW'(GAP);
    end else if (gap_cnt != '0) begin
      gap_cnt <= gap_cnt - 1'b1;
    end
  end

  assign last     = (tries == AW'(LIMIT - 1));
  assign gap_idle = (gap_cnt == '0);
endmodule

// File: rtl/mbx_resp_judge.sv
module mbx_resp_judge
  import mbx_pkg::*;
(
  input  logic [WORD_W-1:0] rsp,
  input  logic [2:0]        kind,
  input  logic              rflag,
  input  logic              after_hdr,
  output logic              released,
  output mbx_result_e       verdict
);
  logic all_ones;
  logic fields_ok;

  assign all_ones  = (rsp == '1);
  assign released  = !rsp[F_OWNER] || (after_hdr && rflag && all_ones);
  assign fields_ok = (rsp[F_KIND_LO +: 3] == kind) &&
                     (rsp[F_VER_LO +: 3] <= REQ_VERSION) &&
                     rsp[F_DIR] &&
                     (rsp[F_STAT_LO +: 8] == 8'd0);

  always_comb begin
    if (rflag && all_ones) verdict = RES_OK;
    else if (fields_ok)    verdict = RES_OK;
    else                   verdict = RES_PROTO;
  end
endmodule

// File: rtl/mbx_req_seq.sv
module mbx_req_seq
  import mbx_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int VIDX_W     = 32,
  parameter int POLL_LIMIT = 20000,
  parameter int POLL_GAP   = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_teardown,
  input  logic              reset_flag,
  input  logic [ADDR_W-1:0] eq_addr,
  input  logic [ADDR_W-1:0] cq_addr,
  input  logic [ADDR_W-1:0] rq_addr,
  input  logic [ADDR_W-1:0] sq_addr,
  input  logic [VIDX_W-1:0] vec_idx,
  output logic              busy,
  output logic              done,
  output logic [1:0]        result,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_write,
  output logic [2:0]        bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic              rd_valid,
  input  logic [31:0]       rd_data
);
  localparam int NQ = 4;

  mbx_state_e                 st;
  logic                       after_hdr;
  logic                       op_q;
  logic                       rflag_q;
  logic [NQ-1:0][ADDR_W-1:0]  addr_q;
  logic [VIDX_W-1:0]          vec_q;
  logic [2:0]                 idx_q;
  mbx_result_e                res_q;

  logic [2:0]                 kind;
  logic [WORD_W-1:0]          hdr;
  logic [MSG_W-1:0]           msg;
  logic [MSG_WORDS-1:0][WORD_W-1:0] msg_words;
  logic                       args_ok;
  logic                       released;
  mbx_result_e                verdict;
  logic                       poll_last;
  logic                       gap_idle;
  logic                       tmr_clr;
  logic                       tmr_miss;
  logic                       wr_fire;
  logic                       rd_back;

  assign kind      = op_q ? KIND_TEARDOWN : KIND_SETUP;
  assign hdr       = make_header(kind, rflag_q);
  assign msg_words = msg;

  mbx_msg_packer #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .VIDX_W(VIDX_W), .NQ(NQ)
  ) u_pack (
    .addrs(addr_q), .vec(vec_q), .hdr(hdr), .msg(msg), .args_ok(args_ok)
  );

  mbx_resp_judge u_judge (
    .rsp(rd_data), .kind(kind), .rflag(rflag_q), .after_hdr(after_hdr),
    .released(released), .verdict(verdict)
  );

  mbx_poll_timer #(.LIMIT(POLL_LIMIT), .GAP(POLL_GAP)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .miss(tmr_miss),
    .last(poll_last), .gap_idle(gap_idle)
  );

  assign wr_fire  = (st == S_WR) && bus_ready;
  assign rd_back  = (st == S_RWAIT) && rd_valid;
  assign tmr_clr  = ((st == S_IDLE) && start) || (wr_fire && idx_q == HDR_WORD);
  assign tmr_miss = rd_back && !released && !poll_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      after_hdr <= 1'b0;
      op_q      <= 1'b0;
      rflag_q   <= 1'b0;
      addr_q    <= '0;
      vec_q     <= '0;
      idx_q     <= '0;
      res_q     <= RES_OK;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          op_q      <= op_teardown;
          rflag_q   <= reset_flag;
          addr_q    <= {sq_addr, rq_addr, cq_addr, eq_addr};
          vec_q     <= vec_idx;
          after_hdr <= 1'b0;
          st        <= S_RD;
        end
        S_RD: if (bus_ready) st <= S_RWAIT;
        S_RWAIT: if (rd_valid) begin
          if (released) begin
            if (after_hdr) begin
              res_q <= verdict;
              st    <= S_FIN;
            end else if (op_q) begin
              idx_q <= HDR_WORD;
              st    <= S_WR;
            end else if (!args_ok) begin
              res_q <= RES_BADARG;
              st    <= S_FIN;
            end else begin
              idx_q <= '0;
              st    <= S_WR;
            end
          end else if (poll_last) begin
            res_q <= RES_TIMEOUT;
            st    <= S_FIN;
          end else begin
            st <= S_GAP;
          end
        end
        S_GAP: if (gap_idle) st <= S_RD;
        S_WR: if (bus_ready) begin
          if (idx_q == HDR_WORD) begin
            after_hdr <= 1'b1;
            st        <= S_RD;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign result    = res_q;
  assign bus_valid = (st == S_RD) || (st == S_WR);
  assign bus_write = (st == S_WR);
  assign bus_addr  = (st == S_WR) ? idx_q : HDR_WORD;
  assign bus_wdata = (st == S_WR) ? msg_words[idx_q] : '0;
endmodule

// File: rtl/mbx_req_seq_chk.sv
module mbx_req_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        bus_valid,
  input logic        bus_ready,
  input logic        bus_write,
  input logic [2:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        rd_valid
);
  logic rd_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                rd_pending <= 1'b0;
    else if (bus_valid && bus_ready && !bus_write) rd_pending <= 1'b1;
    else if (rd_valid)                         rd_pending <= 1'b0;
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_write) &&
                                $stable(bus_addr) && $stable(bus_wdata)); // R11
  AST_ONE_READ_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pending |-> !bus_valid); // R11
  AST_READ_WORD7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_write |-> bus_addr == 3'd7); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R10
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy); // R10
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_valid); // R10
endmodule

bind mbx_req_seq mbx_req_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid)
);

// File: tb/mbx_req_seq_bench.sv
`timescale 1ns/1ps
module mbx_req_seq_bench;
  localparam int LIMIT = 6;
  localparam int GAP   = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0, op_teardown = 0, reset_flag = 0;
  logic [63:0] eq_addr = 0, cq_addr = 0, rq_addr = 0, sq_addr = 0;
  logic [31:0] vec_idx = 0;
  logic busy, done, bus_valid, bus_write;
  logic [1:0] result;
  logic [2:0] bus_addr;
  logic [31:0] bus_wdata;
  logic bus_ready = 0, rd_valid = 0;
  logic [31:0] rd_data = 0;

  always #5 clk = ~clk;

  mbx_req_seq #(.POLL_LIMIT(LIMIT), .POLL_GAP(GAP)) u_mbx_req_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_teardown(op_teardown),
    .reset_flag(reset_flag), .eq_addr(eq_addr), .cq_addr(cq_addr),
    .rq_addr(rq_addr), .sq_addr(sq_addr), .vec_idx(vec_idx), .busy(busy),
    .done(done), .result(result), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int checks = 0, errors = 0;
  // far-side model and reference state
  logic [34:0] exp_q[$];
  int cyc = 0, rd_wait = 0;
  logic [31:0] rd_val = 0, busy_word = 0, idle_word = 0;
  int busy_cnt = 0, post_n = 0;
  logic [31:0] rsp_word = 0;
  bit in_post = 0;
  int pre_reads = 0, post_reads = 0, last_rd = -1000;
  bit gap_bad = 0;
  int done_cnt = 0;
  logic [1:0] got_res = 0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    rd_valid = 0;
    if (rd_wait > 0) begin
      rd_wait--;
      if (rd_wait == 0) begin rd_valid = 1; rd_data = rd_val; end
    end
    bus_ready = (cyc % 3) != 1;
    if (rst_n && bus_valid && bus_ready) begin
      if (bus_write) begin
        if (exp_q.size() == 0) begin
          chk(0, "R3 unexpected write", {29'd0, bus_addr, bus_wdata}, 64'h0);
        end else begin
          logic [34:0] e;
          e = exp_q.pop_front();
          chk({bus_addr, bus_wdata} == e, "R7 R4 write word", {29'd0, bus_addr, bus_wdata}, {29'd0, e});
        end
        if (bus_addr == 3'd7) begin
          in_post = 1; busy_cnt = post_n; busy_word = 32'h8000_0000;
          idle_word = rsp_word; last_rd = -1000;
        end
      end else begin
        if (in_post) post_reads++; else pre_reads++;
        if (cyc - last_rd <= GAP) gap_bad = 1;
        last_rd = cyc;
        if (bus_addr != 3'd7) gap_bad = 1;
        rd_val = (busy_cnt > 0) ? busy_word : idle_word;
        if (busy_cnt > 0) busy_cnt--;
        rd_wait = 2;
      end
    end
    if (done) begin done_cnt++; got_res = result; end
  end

  function automatic logic [31:0] pack_word(input int w, input logic [63:0] a[4],
                                            input logic [31:0] vec, input bit op, input bit rf);
    logic [7:0] b[32];
    logic [15:0] nib;
    logic [51:0] fr;
    nib = 0;
    for (int q = 0; q < 4; q++) begin
      fr = a[q] >> 12;
      for (int k = 0; k < 6; k++) b[6*q+k] = fr[8*k +: 8];
      nib = nib | (16'(fr[51:48]) << (4*q));
    end
    b[24] = nib[7:0];  b[25] = nib[15:8];
    b[26] = vec[7:0];  b[27] = vec[15:8];
    b[28] = op ? 8'd2 : 8'd1; b[29] = 0; b[30] = 0; b[31] = {7'd0, rf};
    return {b[4*w+3], b[4*w+2], b[4*w+1], b[4*w]};
  endfunction

  task automatic run_req(input string tag, input bit op, input bit rf,
                         input logic [63:0] a0, a1, a2, a3, input logic [31:0] vec,
                         input int pre_n, input logic [31:0] pre_word,
                         input int pn, input logic [31:0] rsp,
                         input logic [1:0] exp_res, input bit mid_start);
    logic [63:0] a[4];
    bit args_ok, writes, rel;
    int exp_pre, exp_post, base_done, waited;
    a[0] = a0; a[1] = a1; a[2] = a2; a[3] = a3;
    @(negedge clk);
    exp_q.delete();
    in_post = 0; busy_cnt = pre_n; busy_word = pre_word; idle_word = 32'h0;
    post_n = pn; rsp_word = rsp; pre_reads = 0; post_reads = 0;
    last_rd = -1000; gap_bad = 0; base_done = done_cnt;
    args_ok = (a0[11:0] == 0) && (a1[11:0] == 0) && (a2[11:0] == 0) &&
              (a3[11:0] == 0) && (vec < 32'h10000);
    exp_pre = (pre_n < LIMIT) ? pre_n + 1 : LIMIT;
    writes  = (pre_n < LIMIT) && (op || args_ok);
    rel     = !rsp[31] || (rf && rsp == 32'hFFFF_FFFF);
    exp_post = !writes ? 0 : ((pn < LIMIT && rel) ? pn + 1 : LIMIT);
    if (writes) begin
      if (op) exp_q.push_back({3'd7, pack_word(7, a, vec, op, rf)});
      else for (int w = 0; w < 8; w++) exp_q.push_back({3'(w), pack_word(w, a, vec, op, rf)});
    end
    op_teardown = op; reset_flag = rf; eq_addr = a0; cq_addr = a1;
    rq_addr = a2; sq_addr = a3; vec_idx = vec; start = 1;
    @(negedge clk);
    start = 0;
    if (mid_start) begin
      repeat (3) @(negedge clk);
      op_teardown = ~op; reset_flag = ~rf; eq_addr = 64'h5000; start = 1;
      @(negedge clk);
      start = 0;
    end
    waited = 0;
    while (done_cnt == base_done && waited < 2000) begin @(negedge clk); waited++; end
    chk(waited < 2000, {tag, " watchdog"}, waited, 0);
    repeat (3) @(negedge clk);
    chk(got_res == exp_res, {tag, " result"}, got_res, exp_res);
    chk(done_cnt == base_done + 1, "R10 one done per request", done_cnt - base_done, 1);
    chk(!busy, "R10 busy low after done", busy, 0);
    chk(exp_q.size() == 0, "R7 all expected writes seen", exp_q.size(), 0);
    chk(pre_reads == exp_pre, "R1 R2 reads before writing", pre_reads, exp_pre);
    chk(post_reads == exp_post, "R2 R8 reads after header", post_reads, exp_post);
    chk(!gap_bad, "R2 read spacing and word", gap_bad, 0);
  endtask

  localparam logic [63:0] A0 = 64'h0000_0001_2345_6000, A1 = 64'h0000_00AB_CDEF_1000;
  localparam logic [63:0] A2 = 64'h0000_0000_0007_F000, A3 = 64'h0000_7FFF_FFFF_F000;

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !bus_valid, "R10 reset state", {busy, done, bus_valid}, 0);
    rst_n = 1;
    // R4 R5 R6 R7 R8 basic setup
    run_req("R8 setup ok", 0, 0, A0, A1, A2, A3, 32'h23, 0, 32'h8000_0000, 1, 32'h0000_0081, 2'd0, 0);
    // R1 ownership wait
    run_req("R1 pre wait", 0, 0, A0, A1, A2, A3, 32'h1, 2, 32'h8000_0000, 0, 32'h0000_0081, 2'd0, 0);
    // R5 R3 high nibbles, vector boundary, reset flag in header
    run_req("R5 nibbles", 0, 1, 64'h1234_5678_9ABC_D000, 64'hFEDC_BA98_7654_3000,
            64'h8000_0000_0000_0000, 64'h0FFF_FFFF_FFFF_F000, 32'hFFFF, 0, 32'h8000_0000, 0, 32'h81, 2'd0, 0);
    run_req("R3 unaligned", 0, 0, A0, 64'h0000_00AB_CDEF_1800, A2, A3, 32'h5, 0, 32'h8000_0000, 0, 32'h81, 2'd1, 0);
    run_req("R3 vector wide", 0, 0, A0, A1, A2, A3, 32'h0001_0000, 0, 32'h8000_0000, 0, 32'h81, 2'd1, 0);
    run_req("R2 pre timeout", 0, 0, A0, A1, A2, A3, 32'h2, 100, 32'h8000_0000, 0, 32'h81, 2'd2, 0);
    run_req("R1 all-ones pre", 0, 1, A0, A1, A2, A3, 32'h2, 100, 32'hFFFF_FFFF, 0, 32'h81, 2'd2, 0);
    run_req("R2 post timeout", 0, 0, A0, A1, A2, A3, 32'h2, 0, 32'h8000_0000, 100, 32'h81, 2'd2, 0);
    run_req("R7 teardown", 1, 0, A0, A1, A2, A3, 32'h0, 0, 32'h8000_0000, 1, 32'h0000_0082, 2'd0, 0);
    run_req("R9 reset ones", 1, 1, A0, A1, A2, A3, 32'h0, 0, 32'h8000_0000, 2, 32'hFFFF_FFFF, 2'd0, 0);
    run_req("R9 ones no flag", 0, 0, A0, A1, A2, A3, 32'h0, 0, 32'h8000_0000, 0, 32'hFFFF_FFFF, 2'd2, 0);
    run_req("R8 wrong kind", 0, 0, A0, A1, A2, A3, 32'h9, 0, 32'h8000_0000, 0, 32'h0000_0082, 2'd3, 0);
    run_req("R8 newer version", 1, 0, A0, A1, A2, A3, 32'h0, 0, 32'h8000_0000, 0, 32'h0000_008A, 2'd3, 0);
    run_req("R8 request direction", 0, 0, A0, A1, A2, A3, 32'h9, 0, 32'h8000_0000, 0, 32'h0000_0001, 2'd3, 0);
    run_req("R8 nonzero status", 0, 0, A0, A1, A2, A3, 32'h9, 0, 32'h8000_0000, 0, 32'h0000_0181, 2'd3, 0);
    run_req("R10 start while busy", 0, 0, A0, A1, A2, A3, 32'h44, 1, 32'h8000_0000, 0, 32'h81, 2'd0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule